// File: doc/BRIEF.md
# Byte-Serial Load/Store Unit

This unit carries out the data-memory half of 32-bit integer load and store instructions over a narrow external bus that moves one byte per clock. The core issues a single-cycle start pulse with the access kind, the effective address and, for stores, the data to write. The unit then walks the addressed bytes one after another. Loads build the result from the least significant byte upward and widen it with sign or zero fill. Stores spend one setup cycle and then write each byte with a one-cycle strobe.

The external address is the low part of the effective address. The unit does not check alignment: a halfword or word at any address uses the consecutive byte addresses that follow it, and wraps at the top of the external address space. A done pulse marks the cycle of the last byte. The load result is valid in that cycle and holds until the next accepted start.

The controller has four named states. `ST_IDLE` waits for a start. `ST_PREP` is the store setup cycle. `ST_READ` covers one load byte per cycle, and `ST_WRITE` covers one store byte per cycle. The transitions are:
- `ST_IDLE` to `ST_READ` on a load start.
- `ST_IDLE` to `ST_PREP` on a store start.
- `ST_PREP` to `ST_WRITE` always.
- `ST_READ` or `ST_WRITE` to `ST_IDLE` after the last byte.
- `ST_READ` or `ST_WRITE` to itself, with the byte index advanced, for every other byte.

Top module: `bsl_unit`

## Requirements
- R1: While reset is held, and on its release, both strobes and the done pulse are low and the load result is zero.
- R2: A load whose start is accepted at a clock edge asserts the read strobe in exactly the next 1, 2 or 4 consecutive cycles, for a byte, halfword or word access. The size code is 0 for byte, 1 for halfword, and 2 or 3 for word.
- R3: A store spends exactly one cycle after its accepted start with no strobe asserted. It then asserts the write strobe in exactly 1, 2 or 4 consecutive cycles, so a byte store takes 2 cycles, a halfword store 3 and a word store 5.
- R4: Byte k of an access (k counting from 0) is presented at the low 16 bits of the effective address plus k, modulo 2^16. A misaligned address is used as given, with no special handling.
- R5: Byte order is little-endian. The load byte at index k lands in result bits 8k+7:8k, and the store byte at index k is taken from write-data bits 8k+7:8k.
- R6: With the unsigned flag at 0, byte and halfword loads copy their top loaded bit into all upper result bits. With the flag at 1, they fill the upper bits with zeros. Word loads return all 32 loaded bits.
- R7: The done pulse is high only in the cycle of the last byte strobe, with the full load result visible on the result output in that cycle. In the following cycle no strobe is asserted, and the load result keeps its value.
- R8: A start pulse that arrives while an access is in progress is ignored. Its address, kind and data change neither the ongoing byte sequence nor the result.
- R9: The read and write strobes are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted only when idle |
| op_store_i | input | 1 | 1 = store, 0 = load |
| op_size_i | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| op_unsigned_i | input | 1 | 1 = zero-extend a load, 0 = sign-extend |
| addr_i | input | 32 | Effective address |
| wdata_i | input | 32 | Store data |
| bus_rdata_i | input | 8 | Byte returned by memory in a read-strobe cycle |
| bus_addr_o | output | 16 | External byte address |
| bus_wdata_o | output | 8 | Byte to write |
| bus_rd_o | output | 1 | Read strobe |
| bus_wr_o | output | 1 | Write strobe |
| done_o | output | 1 | Last-byte pulse |
| rdata_o | output | 32 | Extended load result |

## Verification
The bound checker watches, on every cycle, several properties that hold whatever the data is:
- The two strobes are exclusive.
- Within a burst, each strobe cycle advances the address by one.
- Done coincides with a strobe and is always followed by a quiet cycle.
- A write burst begins two cycles after a start, and a read burst one cycle after.

Only the bench scenarios can show the rest, because it depends on data and counting. This covers the exact number of strobe cycles for each size, the byte lanes in little-endian order, sign versus zero fill, address wrap at the top of the external space, and the rejection of a start issued mid-access.

// File: rtl/bsl_pkg.sv
package bsl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PREP  = 2'd1,
        ST_READ  = 2'd2,
        ST_WRITE = 2'd3
    } bsl_state_e;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_WORD3 = 2'd3
    } bsl_size_e;

    typedef struct packed {
        logic      store;
        bsl_size_e size;
        logic      unsgn;
    } bsl_op_t;

endpackage

// File: rtl/bsl_ctrl.sv
module bsl_ctrl
    import bsl_pkg::*;
#(
    parameter int BUS_AW = 16,
    parameter int NBYTES = 4,
    parameter int IDX_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              store_i,
    input  logic [1:0]        size_i,
    input  logic              unsigned_i,
    input  logic [BUS_AW-1:0] addr_i,
    output logic              accept_o,
    output bsl_op_t           op_o,
    output logic [IDX_W-1:0]  idx_o,
    output logic [BUS_AW-1:0] bus_addr_o,
    output logic              rd_o,
    output logic              wr_o,
    output logic              done_o
);

    bsl_state_e        state_q, state_d;
    logic [IDX_W-1:0]  idx_q, idx_d;
    logic [BUS_AW-1:0] base_q;
    bsl_op_t           op_q;
    logic [IDX_W-1:0]  last_idx;
    logic              at_last;
    logic              accept;

    assign accept = (state_q == ST_IDLE) && start_i;

    always_comb begin
        unique case (op_q.size)
            SZ_BYTE: last_idx = '0;
            SZ_HALF: last_idx = IDX_W'(1);
            default: last_idx = IDX_W'(NBYTES - 1);
        endcase
    end

    assign at_last = (idx_q == last_idx);

    // next state and byte index
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_d = store_i ? ST_PREP : ST_READ;
                    idx_d   = '0;
                end
            end
            ST_PREP: state_d = ST_WRITE;
            ST_READ, ST_WRITE: begin
                if (at_last) begin
                    state_d = ST_IDLE;
                end else begin
                    idx_d = idx_q + IDX_W'(1);
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            base_q  <= '0;
            op_q    <= '{store: 1'b0, size: SZ_BYTE, unsgn: 1'b0};
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            if (accept) begin
                base_q <= addr_i;
                op_q   <= '{store: store_i, size: bsl_size_e'(size_i), unsgn: unsigned_i};
            end
        end
    end

    // outputs
    always_comb begin
        rd_o       = 1'b0;
        wr_o       = 1'b0;
        done_o     = 1'b0;
        bus_addr_o = base_q + BUS_AW'(idx_q);
        unique case (state_q)
            ST_IDLE, ST_PREP: ;
            ST_READ: begin
                rd_o   = 1'b1;
                done_o = at_last;
            end
            ST_WRITE: begin
                wr_o   = 1'b1;
                done_o = at_last;
            end
        endcase
    end

    assign accept_o = accept;
    assign op_o     = op_q;
    assign idx_o    = idx_q;

endmodule

// File: rtl/bsl_lane.sv
module bsl_lane
    import bsl_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NBYTES = 4,
    parameter int IDX_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic              rd_en_i,
    input  logic [7:0]        rbyte_i,
    input  bsl_size_e         size_i,
    input  logic              unsigned_i,
    output logic [7:0]        wbyte_o,
    output logic [DATA_W-1:0] result_o
);

    logic [DATA_W-1:0] wbuf_q;
    logic [DATA_W-1:0] acc_q;
    logic [DATA_W-1:0] merged;
    logic              fill;

    // each lane takes the live bus byte when it is the one being read
    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        assign merged[g*8 +: 8] = (rd_en_i && (idx_i == IDX_W'(g))) ? rbyte_i : acc_q[g*8 +: 8];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wbuf_q <= '0;
            acc_q  <= '0;
        end else if (clear_i) begin
            wbuf_q <= wdata_i;
            acc_q  <= '0;
        end else if (rd_en_i) begin
            acc_q  <= merged;
        end
    end

    assign wbyte_o = wbuf_q[{idx_i, 3'b000} +: 8];

    always_comb begin
        unique case (size_i)
            SZ_BYTE: begin
                fill     = ~unsigned_i & merged[7];
                result_o = {{(DATA_W-8){fill}}, merged[7:0]};
            end
            SZ_HALF: begin
                fill     = ~unsigned_i & merged[15];
                result_o = {{(DATA_W-16){fill}}, merged[15:0]};
            end
            default: begin
                fill     = 1'b0;
                result_o = merged;
            end
        endcase
    end

endmodule

// File: rtl/bsl_unit.sv
module bsl_unit
    import bsl_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int BUS_AW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              op_store_i,
    input  logic [1:0]        op_size_i,
    input  logic              op_unsigned_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [7:0]        bus_rdata_i,
    output logic [BUS_AW-1:0] bus_addr_o,
    output logic [7:0]        bus_wdata_o,
    output logic              bus_rd_o,
    output logic              bus_wr_o,
    output logic              done_o,
    output logic [DATA_W-1:0] rdata_o
);

    localparam int NBYTES = DATA_W / 8;
    localparam int IDX_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1;

    logic             accept;
    bsl_op_t          op;
    logic [IDX_W-1:0] idx;

    if (ADDR_W > BUS_AW) begin : g_hi
        logic addr_hi_unused;
        assign addr_hi_unused = ^addr_i[ADDR_W-1:BUS_AW];
    end

    bsl_ctrl #(
        .BUS_AW (BUS_AW),
        .NBYTES (NBYTES),
        .IDX_W  (IDX_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .store_i    (op_store_i),
        .size_i     (op_size_i),
        .unsigned_i (op_unsigned_i),
        .addr_i     (addr_i[BUS_AW-1:0]),
        .accept_o   (accept),
        .op_o       (op),
        .idx_o      (idx),
        .bus_addr_o (bus_addr_o),
        .rd_o       (bus_rd_o),
        .wr_o       (bus_wr_o),
        .done_o     (done_o)
    );

    bsl_lane #(
        .DATA_W (DATA_W),
        .NBYTES (NBYTES),
        .IDX_W  (IDX_W)
    ) u_lane (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (accept),
        .wdata_i    (wdata_i),
        .idx_i      (idx),
        .rd_en_i    (bus_rd_o),
        .rbyte_i    (bus_rdata_i),
        .size_i     (op.size),
        .unsigned_i (op.unsgn),
        .wbyte_o    (bus_wdata_o),
        .result_o   (rdata_o)
    );

endmodule

// File: rtl/bsl_unit_chk.sv
module bsl_unit_chk #(
    parameter int BUS_AW = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              bus_rd_i,
    input logic              bus_wr_i,
    input logic [BUS_AW-1:0] bus_addr_i,
    input logic              done_i
);

    // R9
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd_i && bus_wr_i));

    // R4
    rd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_i && $past(bus_rd_i)) |-> (bus_addr_i == BUS_AW'($past(bus_addr_i) + 1'b1)));

    // R4
    wr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && $past(bus_wr_i)) |-> (bus_addr_i == BUS_AW'($past(bus_addr_i) + 1'b1)));

    // R7
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |=> (!bus_rd_i && !bus_wr_i));

    // R7
    done_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |-> (bus_rd_i || bus_wr_i));

    // R3
    wr_prep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_wr_i) |-> ($past(!bus_rd_i && !bus_wr_i) && $past(start_i, 2)));

    // R2
    rd_begin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_rd_i) |-> $past(start_i));

endmodule

bind bsl_unit bsl_unit_chk #(.BUS_AW(BUS_AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .bus_rd_i   (bus_rd_o),
    .bus_wr_i   (bus_wr_o),
    .bus_addr_i (bus_addr_o),
    .done_i     (done_o)
);

// File: tb/bsl_unit_test.sv
`timescale 1ns/1ps
module bsl_unit_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start_i;
    logic        op_store_i;
    logic [1:0]  op_size_i;
    logic        op_unsigned_i;
    logic [31:0] addr_i;
    logic [31:0] wdata_i;
    logic [7:0]  bus_rdata_i;
    logic [15:0] bus_addr_o;
    logic [7:0]  bus_wdata_o;
    logic        bus_rd_o;
    logic        bus_wr_o;
    logic        done_o;
    logic [31:0] rdata_o;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    bsl_unit uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .op_store_i    (op_store_i),
        .op_size_i     (op_size_i),
        .op_unsigned_i (op_unsigned_i),
        .addr_i        (addr_i),
        .wdata_i       (wdata_i),
        .bus_rdata_i   (bus_rdata_i),
        .bus_addr_o    (bus_addr_o),
        .bus_wdata_o   (bus_wdata_o),
        .bus_rd_o      (bus_rd_o),
        .bus_wr_o      (bus_wr_o),
        .done_o        (done_o),
        .rdata_o       (rdata_o)
    );

    function automatic logic [7:0] pat(input logic [15:0] a);
        pat = (a[7:0] * 8'd37) ^ a[15:8] ^ 8'hA5;
    endfunction

    assign bus_rdata_i = pat(bus_addr_o);

    function automatic int nbytes(input logic [1:0] sz);
        nbytes = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    endfunction

    function automatic logic [31:0] exp_load(input logic [1:0] sz, input logic un, input logic [31:0] a);
        logic [31:0] v = '0;
        for (int j = 0; j < nbytes(sz); j++) v[j*8 +: 8] = pat(a[15:0] + 16'(j));
        if (sz == 2'd0 && !un && v[7])  v[31:8]  = '1;
        if (sz == 2'd1 && !un && v[15]) v[31:16] = '1;
        return v;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // inject > 0: pulse a conflicting start in that cycle of the access
    task automatic run_op(input logic st, input logic [1:0] sz, input logic un,
                          input logic [31:0] a, input logic [31:0] wd, input int inject);
        int n = nbytes(sz);
        int total = st ? n + 1 : n;
        logic [31:0] eres = exp_load(sz, un, a);
        @(negedge clk);
        start_i = 1'b1; op_store_i = st; op_size_i = sz; op_unsigned_i = un;
        addr_i = a; wdata_i = wd;
        @(negedge clk);
        start_i = 1'b0;
        for (int k = 1; k <= total + 1; k++) begin
            int j = st ? k - 2 : k - 1;
            bit e_rd = !st && k <= n;
            bit e_wr = st && k >= 2 && k <= n + 1;
            if (k > 1) @(negedge clk);
            start_i = 1'b0;
            chk(bus_rd_o == e_rd, st ? "R3 read strobe" : "R2 read strobe", 32'(bus_rd_o), 32'(e_rd));
            chk(bus_wr_o == e_wr, st ? "R3 write strobe" : "R2 write strobe", 32'(bus_wr_o), 32'(e_wr));
            chk(done_o == (k == total), "R7 done", 32'(done_o), 32'(k == total));
            if (e_rd || e_wr)
                chk(bus_addr_o == a[15:0] + 16'(j), "R4 address", 32'(bus_addr_o), 32'(a[15:0] + 16'(j)));
            if (e_wr)
                chk(bus_wdata_o == wd[j*8 +: 8], "R5 store byte", 32'(bus_wdata_o), 32'(wd[j*8 +: 8]));
            if (!st && k >= total)
                chk(rdata_o == eres, (k == total) ? "R6 load result" : "R7 result held", rdata_o, eres);
            if (k == inject) begin
                // R8: conflicting request while busy
                start_i = 1'b1; op_store_i = ~st; op_size_i = 2'd0; op_unsigned_i = ~un;
                addr_i = ~a; wdata_i = ~wd;
            end
        end
    endtask

    initial begin
        void'($urandom(32'd9137));
        rst_n = 1'b0; start_i = 1'b0; op_store_i = 1'b0; op_size_i = 2'd0;
        op_unsigned_i = 1'b0; addr_i = '0; wdata_i = '0;
        repeat (3) @(negedge clk);
        // R1 during reset
        chk(!bus_rd_o && !bus_wr_o && !done_o, "R1 strobes in reset", {bus_rd_o, bus_wr_o, done_o}, 0);
        chk(rdata_o == 32'd0, "R1 result in reset", rdata_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!bus_rd_o && !bus_wr_o && !done_o, "R1 strobes after reset", {bus_rd_o, bus_wr_o, done_o}, 0);

        // directed corners
        run_op(1'b0, 2'd0, 1'b0, 32'h0000_0003, '0, 0);           // signed byte
        run_op(1'b0, 2'd0, 1'b1, 32'h0000_0003, '0, 0);           // unsigned byte
        run_op(1'b0, 2'd1, 1'b0, 32'h0000_0101, '0, 0);           // odd halfword
        run_op(1'b0, 2'd1, 1'b1, 32'h0000_0101, '0, 0);
        run_op(1'b0, 2'd2, 1'b0, 32'hABCD_FFFE, '0, 0);           // wraps 16-bit space
        run_op(1'b0, 2'd3, 1'b0, 32'h0000_1235, '0, 0);           // size code 3 is word
        run_op(1'b1, 2'd2, 1'b0, 32'h0001_FFFF, 32'hDEAD_BEEF, 0); // wrapping store
        run_op(1'b1, 2'd0, 1'b0, 32'h0000_0040, 32'h1122_3344, 0);
        run_op(1'b1, 2'd1, 1'b0, 32'h0000_0077, 32'hCAFE_F00D, 0);
        run_op(1'b1, 2'd2, 1'b0, 32'h0000_2000, 32'h0102_0304, 2); // R8 mid-store
        run_op(1'b0, 2'd2, 1'b1, 32'h0000_3001, '0, 1);            // R8 mid-load

        // constrained random mix
        for (int i = 0; i < 200; i++) begin
            logic        st = 1'($urandom);
            logic [1:0]  sz = 2'($urandom);
            logic        un = 1'($urandom);
            logic [31:0] a  = $urandom;
            logic [31:0] wd = $urandom;
            int          inj = ($urandom % 4 == 0) ? 1 : 0;
            if (inj == 1 && !st && sz == 2'd0) inj = 0;
            run_op(st, sz, un, a, wd, inj);
            if ($urandom % 3 == 0) @(negedge clk);
        end

        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule